// File: doc/BRIEF.md
# CAN Fault Confinement Controller

This block keeps the error health of a single CAN node. It holds a transmit error counter and a receive error counter. It updates both from one-cycle event strobes that the protocol engine raises when a frame error or a successful frame is seen. From those counters it derives the node's confinement state. The state drives the two status flags, a one-cycle interrupt on entry to bus off, and three permission outputs for the engine: whether it may send active error flags, whether it may drive the bus at all, and whether it must insert the extra suspend time after a transmission.

The controller is a three-state machine: `ST_ACTIVE` (the state after reset), `ST_PASSIVE` and `ST_BUS_OFF`. Its transitions are:
- `ACTIVE->PASSIVE`, taken when either counter exceeds 127.
- `PASSIVE->ACTIVE`, taken when both counters are at or below 127.
- `ACTIVE/PASSIVE->BUS_OFF`, taken when the transmit counter exceeds 255. This check has priority over the other two.
- `BUS_OFF->ACTIVE`, taken once 128 runs of 11 consecutive recessive bits have been seen on the sampled bus bit stream. This transition clears both counters.

All transitions are evaluated on the registered counter values, so a state change appears one clock after the counter value that causes it.

Top module: `can_fault_guard`

## Requirements
- R1: After reset the state is ACTIVE, both counters read 0, `passive_flag`, `busoff_flag` and `busoff_irq` are 0, and `active_flag_en` and `bus_drive_en` are 1.
- R2: Outside bus off, the transmit counter adds 8 on `tx_err_evt` and then subtracts 1 on `tx_ok_evt`. The subtraction is skipped when the sum is 0, so the counter never goes below 0. The counter saturates at its all-ones value.
- R3: Outside bus off, the receive counter adds 1 on `rx_err_evt` and then subtracts 1 on `rx_ok_evt`. It never goes below 0 and saturates at 255 rather than wrapping.
- R4: Event strobes raised in the same cycle are all applied in that cycle.
- R5: ACTIVE moves to PASSIVE one clock after either counter exceeds 127.
- R6: PASSIVE returns to ACTIVE one clock after both counters are at or below 127.
- R7: ACTIVE or PASSIVE moves to BUS_OFF one clock after the transmit counter exceeds 255. While in BUS_OFF, all four event strobes are ignored and both counters hold.
- R8: In BUS_OFF, each `bus_bit_vld` cycle with `bus_bit_rec`=1 extends the current recessive run, and every 11th bit of a run completes one run. A valid bit with `bus_bit_rec`=0 restarts the current run but keeps the completed runs. The clock after the edge that completes the 128th run, the state is ACTIVE and both counters are 0.
- R9: The flags encode the state as {`passive_flag`,`busoff_flag`}: ACTIVE=00, PASSIVE=10, BUS_OFF=01.
- R10: `busoff_irq` is high for exactly the first cycle in which `busoff_flag` is high, and only when `boff_irq_en` was 1 on the entering edge. It stays 0 otherwise.
- R11: `active_flag_en` is 1 only in ACTIVE. `tx_suspend_en` is 1 only in PASSIVE. `bus_drive_en` is 0 only in BUS_OFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_err_evt | input | 1 | Transmit error strobe |
| tx_ok_evt | input | 1 | Successful transmit strobe |
| rx_err_evt | input | 1 | Receive error strobe |
| rx_ok_evt | input | 1 | Successful receive strobe |
| bus_bit_vld | input | 1 | Sampled bus bit valid this cycle |
| bus_bit_rec | input | 1 | Sampled bus bit, 1 = recessive |
| boff_irq_en | input | 1 | Enable for the bus-off interrupt |
| tx_err_cnt | output | 9 | Transmit error counter |
| rx_err_cnt | output | 8 | Receive error counter |
| passive_flag | output | 1 | Error-passive status flag |
| busoff_flag | output | 1 | Bus-off status flag |
| busoff_irq | output | 1 | One-cycle bus-off entry interrupt |
| active_flag_en | output | 1 | Engine may send active error flags |
| bus_drive_en | output | 1 | Engine may drive the bus |
| tx_suspend_en | output | 1 | Engine must add suspend time after transmit |

## Verification
The bench targets the boundaries of every transition:
- 128 against 127 on each counter in both directions. A design that compares with `>=` or `<` would change state one event early or stay in the wrong state.
- The receive counter driven far past 255. A wrapping counter would fall back to a small value and silently leave passive.
- Success strobes at a count of 0, and all four strobes in one cycle. A design that drops a simultaneous event, or lets the count go below 0, would show the wrong count.
- Recovery with a dominant bit inside the first run, then exactly one bit short of the target. A design that resets the completed-run count on a dominant bit, or that counts off by one, would leave bus off at the wrong time.
- Bus-off entry with the interrupt both enabled and disabled, to catch a pulse that is missing, stretched, or raised without its enable.

// File: rtl/fcg_pkg.sv
package fcg_pkg;

    typedef enum logic [1:0] {
        ST_ACTIVE  = 2'd0,
        ST_PASSIVE = 2'd1,
        ST_BUS_OFF = 2'd2
    } conf_state_e;

endpackage

// File: rtl/fcg_err_counters.sv
module fcg_err_counters #(
    parameter int TEC_W       = 9,
    parameter int REC_W       = 8,
    parameter int TX_ERR_STEP = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             freeze,
    input  logic             clear,
    input  logic             tx_err,
    input  logic             tx_ok,
    input  logic             rx_err,
    input  logic             rx_ok,
    output logic [TEC_W-1:0] tec,
    output logic [REC_W-1:0] rec
);

    localparam logic [TEC_W:0] TEC_MAX_X = {1'b0, {TEC_W{1'b1}}};
    localparam logic [REC_W:0] REC_MAX_X = {1'b0, {REC_W{1'b1}}};

    logic [TEC_W-1:0] tec_q, tec_d;
    logic [REC_W-1:0] rec_q, rec_d;
    logic [TEC_W:0]   tec_sum;
    logic [REC_W:0]   rec_sum;

    // add first, then the success decrement, then clamp
    always_comb begin
        tec_sum = {1'b0, tec_q} + (tx_err ? (TEC_W+1)'(TX_ERR_STEP) : '0);
        if (tx_ok && (tec_sum != '0)) begin
            tec_sum = tec_sum - 1'b1;
        end
        tec_d = (tec_sum > TEC_MAX_X) ? {TEC_W{1'b1}} : tec_sum[TEC_W-1:0];

        rec_sum = {1'b0, rec_q} + (rx_err ? (REC_W+1)'(1) : '0);
        if (rx_ok && (rec_sum != '0)) begin
            rec_sum = rec_sum - 1'b1;
        end
        rec_d = (rec_sum > REC_MAX_X) ? {REC_W{1'b1}} : rec_sum[REC_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tec_q <= '0;
            rec_q <= '0;
        end else if (clear) begin
            tec_q <= '0;
            rec_q <= '0;
        end else if (!freeze) begin
            tec_q <= tec_d;
            rec_q <= rec_d;
        end
    end

    assign tec = tec_q;
    assign rec = rec_q;

endmodule

// File: rtl/fcg_recovery_monitor.sv
module fcg_recovery_monitor #(
    parameter int RUN_LEN    = 11,
    parameter int RUN_TARGET = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic bit_vld,
    input  logic bit_rec,
    output logic done
);

    localparam int RUN_W = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
    localparam int CNT_W = $clog2(RUN_TARGET + 1);

    logic [RUN_W-1:0] run_q;
    logic [CNT_W-1:0] runs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= '0;
            runs_q <= '0;
        end else if (!arm) begin
            run_q  <= '0;
            runs_q <= '0;
        end else if (bit_vld && !done) begin
            if (!bit_rec) begin
                run_q <= '0;                 // dominant bit restarts the run
            end else if (run_q == RUN_W'(RUN_LEN - 1)) begin
                run_q  <= '0;
                runs_q <= runs_q + 1'b1;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign done = (runs_q == CNT_W'(RUN_TARGET));

endmodule

// File: rtl/can_fault_guard.sv
module can_fault_guard
    import fcg_pkg::*;
#(
    parameter int TEC_W        = 9,
    parameter int REC_W        = 8,
    parameter int TX_ERR_STEP  = 8,
    parameter int PASSIVE_LIM  = 127,
    parameter int BUSOFF_LIM   = 255,
    parameter int RUN_LEN      = 11,
    parameter int RUN_TARGET   = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_err_evt,
    input  logic             tx_ok_evt,
    input  logic             rx_err_evt,
    input  logic             rx_ok_evt,
    input  logic             bus_bit_vld,
    input  logic             bus_bit_rec,
    input  logic             boff_irq_en,
    output logic [TEC_W-1:0] tx_err_cnt,
    output logic [REC_W-1:0] rx_err_cnt,
    output logic             passive_flag,
    output logic             busoff_flag,
    output logic             busoff_irq,
    output logic             active_flag_en,
    output logic             bus_drive_en,
    output logic             tx_suspend_en
);

    conf_state_e state_q, state_d;
    logic        in_bus_off;
    logic        rec_done;
    logic        cnt_clear;
    logic        irq_q;
    logic        tec_over_passive, rec_over_passive, tec_over_busoff;

    assign in_bus_off = (state_q == ST_BUS_OFF);
    assign cnt_clear  = in_bus_off && rec_done;

    fcg_err_counters #(
        .TEC_W       (TEC_W),
        .REC_W       (REC_W),
        .TX_ERR_STEP (TX_ERR_STEP)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .freeze (in_bus_off),
        .clear  (cnt_clear),
        .tx_err (tx_err_evt),
        .tx_ok  (tx_ok_evt),
        .rx_err (rx_err_evt),
        .rx_ok  (rx_ok_evt),
        .tec    (tx_err_cnt),
        .rec    (rx_err_cnt)
    );

    fcg_recovery_monitor #(
        .RUN_LEN    (RUN_LEN),
        .RUN_TARGET (RUN_TARGET)
    ) u_rcv (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (in_bus_off),
        .bit_vld (bus_bit_vld),
        .bit_rec (bus_bit_rec),
        .done    (rec_done)
    );

    assign tec_over_passive = (32'(tx_err_cnt) > PASSIVE_LIM);
    assign rec_over_passive = (32'(rx_err_cnt) > PASSIVE_LIM);
    assign tec_over_busoff  = (32'(tx_err_cnt) > BUSOFF_LIM);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACTIVE: begin
                if (tec_over_busoff)                           state_d = ST_BUS_OFF;
                else if (tec_over_passive || rec_over_passive) state_d = ST_PASSIVE;
            end
            ST_PASSIVE: begin
                if (tec_over_busoff)                              state_d = ST_BUS_OFF;
                else if (!tec_over_passive && !rec_over_passive)  state_d = ST_ACTIVE;
            end
            ST_BUS_OFF: begin
                if (rec_done) state_d = ST_ACTIVE;
            end
            default: state_d = ST_ACTIVE;
        endcase
    end

    // state register and entry interrupt
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ACTIVE;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            irq_q   <= boff_irq_en && (state_d == ST_BUS_OFF) && (state_q != ST_BUS_OFF);
        end
    end

    // output decode
    always_comb begin
        passive_flag   = 1'b0;
        busoff_flag    = 1'b0;
        active_flag_en = 1'b0;
        bus_drive_en   = 1'b1;
        tx_suspend_en  = 1'b0;
        unique case (state_q)
            ST_ACTIVE: begin
                active_flag_en = 1'b1;
            end
            ST_PASSIVE: begin
                passive_flag  = 1'b1;
                tx_suspend_en = 1'b1;
            end
            ST_BUS_OFF: begin
                busoff_flag  = 1'b1;
                bus_drive_en = 1'b0;
            end
            default: begin
                active_flag_en = 1'b1;
            end
        endcase
    end

    assign busoff_irq = irq_q;

endmodule

// File: rtl/fcg_checker.sv
module fcg_checker #(
    parameter int TEC_W       = 9,
    parameter int REC_W       = 8,
    parameter int PASSIVE_LIM = 127,
    parameter int BUSOFF_LIM  = 255
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_err_evt,
    input logic             tx_ok_evt,
    input logic [TEC_W-1:0] tx_err_cnt,
    input logic [REC_W-1:0] rx_err_cnt,
    input logic             passive_flag,
    input logic             busoff_flag,
    input logic             busoff_irq,
    input logic             active_flag_en,
    input logic             bus_drive_en
);

    p_flag_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(passive_flag && busoff_flag));

    p_tec_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busoff_flag && tx_ok_evt && !tx_err_evt && tx_err_cnt == '0) |=> (tx_err_cnt == '0));

    p_tec_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busoff_flag && tx_err_evt && !tx_ok_evt && 32'(tx_err_cnt) < 400)
        |=> (32'(tx_err_cnt) == 32'($past(tx_err_cnt)) + 8));

    p_passive_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busoff_flag && (32'(tx_err_cnt) > PASSIVE_LIM || 32'(rx_err_cnt) > PASSIVE_LIM))
        |=> (passive_flag || busoff_flag));

    p_busoff_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busoff_flag && 32'(tx_err_cnt) > BUSOFF_LIM) |=> busoff_flag);

    p_busoff_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busoff_flag |=> ($stable(tx_err_cnt) || tx_err_cnt == '0));

    p_irq_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busoff_irq |-> (busoff_flag && !$past(busoff_flag)));

    p_no_drive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busoff_flag |-> (!bus_drive_en && !active_flag_en));

endmodule

bind can_fault_guard fcg_checker #(
    .TEC_W       (TEC_W),
    .REC_W       (REC_W),
    .PASSIVE_LIM (PASSIVE_LIM),
    .BUSOFF_LIM  (BUSOFF_LIM)
) u_fcg_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .tx_err_evt     (tx_err_evt),
    .tx_ok_evt      (tx_ok_evt),
    .tx_err_cnt     (tx_err_cnt),
    .rx_err_cnt     (rx_err_cnt),
    .passive_flag   (passive_flag),
    .busoff_flag    (busoff_flag),
    .busoff_irq     (busoff_irq),
    .active_flag_en (active_flag_en),
    .bus_drive_en   (bus_drive_en)
);

// File: tb/tb_can_fault_guard.sv
module tb_can_fault_guard;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_err_evt = 1'b0, tx_ok_evt = 1'b0, rx_err_evt = 1'b0, rx_ok_evt = 1'b0;
    logic       bus_bit_vld = 1'b0, bus_bit_rec = 1'b0, boff_irq_en = 1'b1;
    logic [8:0] tx_err_cnt;
    logic [7:0] rx_err_cnt;
    logic       passive_flag, busoff_flag, busoff_irq;
    logic       active_flag_en, bus_drive_en, tx_suspend_en;

    always #4 clk = ~clk;

    can_fault_guard dut (
        .clk(clk), .rst_n(rst_n),
        .tx_err_evt(tx_err_evt), .tx_ok_evt(tx_ok_evt),
        .rx_err_evt(rx_err_evt), .rx_ok_evt(rx_ok_evt),
        .bus_bit_vld(bus_bit_vld), .bus_bit_rec(bus_bit_rec),
        .boff_irq_en(boff_irq_en),
        .tx_err_cnt(tx_err_cnt), .rx_err_cnt(rx_err_cnt),
        .passive_flag(passive_flag), .busoff_flag(busoff_flag),
        .busoff_irq(busoff_irq), .active_flag_en(active_flag_en),
        .bus_drive_en(bus_drive_en), .tx_suspend_en(tx_suspend_en)
    );

    typedef struct {
        int    tec;
        int    rec;
        int    st;
        bit    irq;
        string tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   failures = 0;
    bit   finished = 0;

    // reference model (0 active, 1 passive, 2 bus off)
    int m_tec = 0, m_rec = 0, m_st = 0, m_run = 0, m_runs = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step(input bit te, input bit to, input bit re, input bit ro,
                        input bit bv, input bit bb, input string tag);
        int  n_tec, n_rec, n_st;
        bit  done;
        exp_t e;
        @(negedge clk);
        tx_err_evt = te; tx_ok_evt = to; rx_err_evt = re; rx_ok_evt = ro;
        bus_bit_vld = bv; bus_bit_rec = bb;
        done  = (m_runs == 128);
        n_tec = m_tec;
        n_rec = m_rec;
        if (m_st == 2) begin
            if (done) begin n_tec = 0; n_rec = 0; end
        end else begin
            n_tec = m_tec + (te ? 8 : 0);
            if (to && n_tec > 0) n_tec--;
            if (n_tec > 511) n_tec = 511;
            n_rec = m_rec + (re ? 1 : 0);
            if (ro && n_rec > 0) n_rec--;
            if (n_rec > 255) n_rec = 255;
        end
        n_st = m_st;
        case (m_st)
            0: if (m_tec > 255) n_st = 2; else if (m_tec > 127 || m_rec > 127) n_st = 1;
            1: if (m_tec > 255) n_st = 2; else if (m_tec <= 127 && m_rec <= 127) n_st = 0;
            default: if (done) n_st = 0;
        endcase
        if (m_st != 2) begin
            m_run = 0; m_runs = 0;
        end else if (bv && !done) begin
            if (!bb) m_run = 0;
            else if (m_run == 10) begin m_run = 0; m_runs++; end
            else m_run++;
        end
        e.tec = n_tec; e.rec = n_rec; e.st = n_st;
        e.irq = boff_irq_en && (n_st == 2) && (m_st != 2);
        e.tag = tag;
        q.push_back(e);
        m_tec = n_tec; m_rec = n_rec; m_st = n_st;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic bits(input int n, input bit rec_bit, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 1, rec_bit, tag);
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk({e.tag, "/R2"}, "tx_err_cnt", int'(tx_err_cnt), e.tec);
                chk({e.tag, "/R3"}, "rx_err_cnt", int'(rx_err_cnt), e.rec);
                chk({e.tag, "/R9"}, "passive_flag", int'(passive_flag), int'(e.st == 1));
                chk({e.tag, "/R9"}, "busoff_flag", int'(busoff_flag), int'(e.st == 2));
                chk({e.tag, "/R10"}, "busoff_irq", int'(busoff_irq), int'(e.irq));
                chk({e.tag, "/R11"}, "active_flag_en", int'(active_flag_en), int'(e.st == 0));
                chk({e.tag, "/R11"}, "bus_drive_en", int'(bus_drive_en), int'(e.st != 2));
                chk({e.tag, "/R11"}, "tx_suspend_en", int'(tx_suspend_en), int'(e.st == 1));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "tx_err_cnt", int'(tx_err_cnt), 0);
        chk("R1", "rx_err_cnt", int'(rx_err_cnt), 0);
        chk("R1", "flags", int'({passive_flag, busoff_flag, busoff_irq}), 0);
        chk("R1", "enables", int'({active_flag_en, bus_drive_en}), 3);
        rst_n = 1'b1;

        // R2: floor at zero, then tx errors to 128
        for (int i = 0; i < 2; i++) step(0, 1, 0, 0, 0, 0, "R2");
        for (int i = 0; i < 16; i++) step(1, 0, 0, 0, 0, 0, "R5");
        idle(2, "R5");
        step(0, 1, 0, 0, 0, 0, "R6");
        idle(2, "R6");
        for (int i = 0; i < 127; i++) step(0, 1, 0, 0, 0, 0, "R2");

        // R3: receive counter up past 255, then back down
        for (int i = 0; i < 300; i++) step(0, 0, 1, 0, 0, 0, "R3");
        idle(2, "R3");
        for (int i = 0; i < 128; i++) step(0, 0, 0, 1, 0, 0, "R6");
        idle(2, "R6");
        for (int i = 0; i < 129; i++) step(0, 0, 0, 1, 0, 0, "R3");

        // R4: all four strobes together
        for (int i = 0; i < 3; i++) step(1, 1, 1, 1, 0, 0, "R4");
        step(0, 0, 1, 0, 0, 0, "R4");
        step(0, 1, 1, 1, 0, 0, "R4");
        idle(2, "R4");

        // R7: drive into bus off with interrupt enabled
        for (int i = 0; i < 33; i++) step(1, 0, 0, 0, 0, 0, "R7");
        idle(2, "R7");
        for (int i = 0; i < 5; i++) step(1, 1, 1, 1, 0, 0, "R7");

        // R8: dominant bit inside a run, then one bit short of the target
        bits(10, 1, "R8");
        bits(1, 0, "R8");
        bits(1407, 1, "R8");
        idle(3, "R8");
        bits(1, 1, "R8");
        idle(3, "R8");

        // R10: second bus-off entry with interrupt disabled
        @(negedge clk);
        boff_irq_en = 1'b0;
        for (int i = 0; i < 34; i++) step(1, 0, 0, 0, 0, 0, "R10");
        idle(3, "R10");
        bits(1408, 1, "R8");
        idle(3, "R8");

        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule